// File: doc/BRIEF.md
# Rotating-Track Word and Sector Timing Generator

This block produces the bit, word and sector timing for a bit-serial machine whose storage is a rotating track. Each clock cycle of `clk` is one bit time of the master bit clock. Each word slot lasts 27 bit times: 24 data bits followed by 3 timing bits. A revolution holds 128 slots, which is 3456 bit times. The block counts the bit position within the slot and the slot (sector) address. It flags data bits and timing bits, and it strobes the first and last bit of every slot.

The counters are only meaningful once they have been tied to the track. A once-per-revolution reference pulse `rev_mark` marks the final bit of the last slot. After power-up (`rst_n`) or a master reset (`mrst`), the block waits in state HUNT with its counters held at zero. The first reference pulse moves it to LOCK, and counting starts from bit 0 of sector 0 on the next cycle. In LOCK, a pulse that arrives exactly at the natural end of the revolution changes nothing. A pulse anywhere else forces both counters to restart and moves the block to SLIP. SLIP keeps counting but latches a lost-alignment flag until the next reset. The transitions are:

- HUNT→LOCK on a reference pulse.
- LOCK→SLIP on a misplaced pulse.
- LOCK→LOCK and SLIP→SLIP otherwise.
- Any state→HUNT on `mrst`.

Top module: `drum_word_timer`

## Requirements
- R1: While aligned (state LOCK or SLIP), `bit_pos` advances by one each cycle from 0 to 26 and then returns to 0.
- R2: While aligned, `data_slot` is high for bit positions 0 to 23 and `timing_slot` is high for bit positions 24 to 26. The two are never high together.
- R3: While aligned, `word_start` is high for exactly the cycle with `bit_pos` = 0, and `word_end` is high for exactly the cycle with `bit_pos` = 26.
- R4: `sector` increments in the cycle after `bit_pos` = 26 and returns from 127 to 0.
- R5: `rst_n` low, or `mrst` high at a clock edge, enters HUNT. In HUNT, `bit_pos` = 0, `sector` = 0, `in_sync` = 0 and `sync_slip` = 0, all strobes and slot flags are 0, and the counters hold until a reference pulse arrives.
- R6: A reference pulse in HUNT is treated as the last bit of sector 127. On the next cycle `in_sync` = 1, `bit_pos` = 0 and `sector` = 0.
- R7: A reference pulse while aligned with `bit_pos` = 26 and `sector` = 127 leaves `sync_slip` unchanged, and counting continues without a break.
- R8: A reference pulse while aligned at any other position gives `bit_pos` = 0 and `sector` = 0 on the next cycle and sets `sync_slip`. `sync_slip` stays set until a reset.
- R9: `mrst` takes precedence over a reference pulse in the same cycle: the block enters HUNT, not LOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock, one bit time per cycle |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| mrst | input | 1 | Synchronous master reset, realigns to the track |
| rev_mark | input | 1 | Once-per-revolution reference, marks the final bit of sector 127 |
| bit_pos | output | 5 | Bit position within the word slot, 0 to 26 |
| sector | output | 7 | Word slot address within the revolution |
| data_slot | output | 1 | High during the 24 data bits |
| timing_slot | output | 1 | High during the 3 timing bits |
| word_start | output | 1 | One-cycle strobe at bit 0 of each slot |
| word_end | output | 1 | One-cycle strobe at bit 26 of each slot |
| in_sync | output | 1 | Counters are aligned to the reference |
| sync_slip | output | 1 | Sticky flag: a reference pulse arrived out of place |

## Verification
The reference pulse and the natural wrap of both counters can fall in the same cycle. A pulse at bit 26 of sector 127 must realign without raising `sync_slip` and without disturbing the count. The bench drives the pulse exactly on that cycle for whole revolutions and compares every output each cycle against a bench-side model. It also places pulses one bit early and at random points, where the slip flag must rise. A second collision, master reset together with a reference pulse, is driven directly, and the bench confirms that the block lands in HUNT.

// File: rtl/drum_timing_pkg.sv
package drum_timing_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LOCK = 2'd1,
        ST_SLIP = 2'd2
    } sync_state_t;
endpackage

// File: rtl/drum_bit_counter.sv
module drum_bit_counter #(
    parameter int SLOT_BITS = 27,
    localparam int BW = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [BW-1:0] cnt,
    output logic          at_last
);
    localparam logic [BW-1:0] LAST = BW'(SLOT_BITS - 1);

    assign at_last = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (at_last) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/drum_sector_counter.sv
module drum_sector_counter #(
    parameter int SECTORS = 128,
    localparam int SW = $clog2(SECTORS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [SW-1:0] cnt,
    output logic          at_last
);
    localparam logic [SW-1:0] LAST = SW'(SECTORS - 1);

    assign at_last = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (adv)     cnt <= at_last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/drum_sync_fsm.sv
module drum_sync_fsm
    import drum_timing_pkg::*;
#(
    parameter int SLOT_BITS = 27,
    parameter int DATA_BITS = 24,
    localparam int BW = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mrst,
    input  logic          rev_mark,
    input  logic [BW-1:0] bit_pos,
    input  logic          bit_last,
    input  logic          sec_last,
    output logic          realign,
    output logic          in_sync,
    output logic          sync_slip,
    output logic          data_slot,
    output logic          timing_slot,
    output logic          word_start,
    output logic          word_end
);
    localparam logic [BW-1:0] FIRST_TIMING = BW'(DATA_BITS);

    sync_state_t state, state_nx;
    logic        rev_end;

    assign rev_end = bit_last && sec_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (mrst) begin
            state_nx = ST_HUNT;
        end else begin
            unique case (state)
                ST_HUNT: if (rev_mark) state_nx = ST_LOCK;
                ST_LOCK: if (rev_mark && !rev_end) state_nx = ST_SLIP;
                ST_SLIP: state_nx = ST_SLIP;
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    always_comb begin
        in_sync     = 1'b0;
        sync_slip   = 1'b0;
        realign     = mrst || rev_mark;
        data_slot   = 1'b0;
        timing_slot = 1'b0;
        word_start  = 1'b0;
        word_end    = 1'b0;
        unique case (state)
            ST_HUNT: realign = 1'b1;
            ST_LOCK, ST_SLIP: begin
                in_sync     = 1'b1;
                sync_slip   = (state == ST_SLIP);
                timing_slot = (bit_pos >= FIRST_TIMING);
                data_slot   = (bit_pos <  FIRST_TIMING);
                word_start  = (bit_pos == '0);
                word_end    = bit_last;
            end
            default: realign = 1'b1;
        endcase
    end
endmodule

// File: rtl/drum_word_timer.sv
module drum_word_timer #(
    parameter int SLOT_BITS = 27,
    parameter int DATA_BITS = 24,
    parameter int SECTORS   = 128,
    localparam int BW = $clog2(SLOT_BITS),
    localparam int SW = $clog2(SECTORS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mrst,
    input  logic          rev_mark,
    output logic [BW-1:0] bit_pos,
    output logic [SW-1:0] sector,
    output logic          data_slot,
    output logic          timing_slot,
    output logic          word_start,
    output logic          word_end,
    output logic          in_sync,
    output logic          sync_slip
);
    logic realign, bit_last, sec_last;

    drum_bit_counter #(.SLOT_BITS(SLOT_BITS)) bit_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(realign),
        .cnt(bit_pos), .at_last(bit_last)
    );

    drum_sector_counter #(.SECTORS(SECTORS)) sec_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(realign), .adv(bit_last),
        .cnt(sector), .at_last(sec_last)
    );

    drum_sync_fsm #(.SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .rev_mark(rev_mark),
        .bit_pos(bit_pos), .bit_last(bit_last), .sec_last(sec_last),
        .realign(realign), .in_sync(in_sync), .sync_slip(sync_slip),
        .data_slot(data_slot), .timing_slot(timing_slot),
        .word_start(word_start), .word_end(word_end)
    );
endmodule

// File: rtl/drum_word_timer_chk.sv
module drum_word_timer_chk #(
    parameter int SLOT_BITS = 27,
    parameter int SECTORS   = 128,
    localparam int BW = $clog2(SLOT_BITS),
    localparam int SW = $clog2(SECTORS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mrst,
    input logic          rev_mark,
    input logic [BW-1:0] bit_pos,
    input logic [SW-1:0] sector,
    input logic          data_slot,
    input logic          timing_slot,
    input logic          word_start,
    input logic          word_end,
    input logic          in_sync,
    input logic          sync_slip
);
    localparam logic [BW-1:0] BLAST = BW'(SLOT_BITS - 1);
    localparam logic [SW-1:0] SLAST = SW'(SECTORS - 1);

    p_bit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= BLAST);

    p_bit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !mrst && !rev_mark && bit_pos != BLAST)
        |=> bit_pos == BW'($past(bit_pos) + 1'b1));

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_slot && timing_slot));

    p_start_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start |-> bit_pos == '0) and (word_end |-> bit_pos == BLAST));

    p_sector_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !mrst && !rev_mark && bit_pos == BLAST && sector == SLAST)
        |=> sector == '0);

    p_mreset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (!in_sync && !sync_slip && bit_pos == '0 && sector == '0));

    p_hunt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |-> (!word_start && !word_end && !data_slot && !timing_slot));

    p_slip_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_slip && !mrst) |=> sync_slip);

    p_mrst_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mrst && rev_mark) |=> !in_sync);
endmodule

bind drum_word_timer drum_word_timer_chk #(
    .SLOT_BITS(SLOT_BITS), .SECTORS(SECTORS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .rev_mark(rev_mark),
    .bit_pos(bit_pos), .sector(sector), .data_slot(data_slot),
    .timing_slot(timing_slot), .word_start(word_start), .word_end(word_end),
    .in_sync(in_sync), .sync_slip(sync_slip)
);

// File: tb/drum_word_timer_tb.sv
module drum_word_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrst = 1'b0;
    logic       rev_mark = 1'b0;
    logic [4:0] bit_pos;
    logic [6:0] sector;
    logic       data_slot, timing_slot, word_start, word_end, in_sync, sync_slip;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model: 0 = waiting, 1 = aligned, 2 = aligned with slip
    int m_st = 0;
    int m_bit = 0;
    int m_sec = 0;

    always #5 clk = ~clk;

    drum_word_timer dut_i (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .rev_mark(rev_mark),
        .bit_pos(bit_pos), .sector(sector), .data_slot(data_slot),
        .timing_slot(timing_slot), .word_start(word_start), .word_end(word_end),
        .in_sync(in_sync), .sync_slip(sync_slip)
    );

    function automatic bit at_rev_end();
        return (m_bit == 26) && (m_sec == 127);
    endfunction

    function automatic bit running();
        return m_st != 0;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (bit=%0d sec=%0d)",
                     req, act, exp, m_bit, m_sec);
        end
    endtask

    task automatic check_all();
        check("R1 bit_pos", int'(bit_pos), running() ? m_bit : 0);
        check("R4 sector", int'(sector), running() ? m_sec : 0);
        check("R2 data_slot", int'(data_slot), int'(running() && m_bit < 24));
        check("R2 timing_slot", int'(timing_slot), int'(running() && m_bit >= 24));
        check("R3 word_start", int'(word_start), int'(running() && m_bit == 0));
        check("R3 word_end", int'(word_end), int'(running() && m_bit == 26));
        check("R6 in_sync", int'(in_sync), int'(running()));
        check("R8 sync_slip", int'(sync_slip), int'(m_st == 2));
    endtask

    task automatic model_step(bit mk, bit mr);
        if (mr) begin
            m_st = 0; m_bit = 0; m_sec = 0;
        end else if (m_st == 0) begin
            if (mk) m_st = 1;
            m_bit = 0; m_sec = 0;
        end else if (mk) begin
            if (!at_rev_end()) m_st = 2;
            m_bit = 0; m_sec = 0;
        end else if (m_bit == 26) begin
            m_bit = 0;
            m_sec = (m_sec + 1) % 128;
        end else begin
            m_bit = m_bit + 1;
        end
    endtask

    task automatic cyc(bit mk, bit mr);
        @(negedge clk);
        rev_mark = mk;
        mrst = mr;
        @(posedge clk);
        model_step(mk, mr);
        #1;
        check_all();
    endtask

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(posedge clk);
        #1;
        check_all();                          // R5 power-up state
        @(negedge clk);
        rst_n = 1'b1;
        // R5: counters hold while waiting
        for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0);
        // R6: first reference pulse aligns
        cyc(1'b1, 1'b0);
        // R1..R4, R7: two revolutions with the pulse exactly at the wrap
        for (int i = 0; i < 2 * 3456 + 5; i++) cyc(at_rev_end(), 1'b0);
        // R8: pulse one bit before the wrap
        for (int i = 0; i < 3456; i++) begin
            if (m_bit == 25 && m_sec == 127) begin
                cyc(1'b1, 1'b0);
                break;
            end
            cyc(1'b0, 1'b0);
        end
        for (int i = 0; i < 500; i++) cyc(at_rev_end(), 1'b0);
        // R9: master reset with a reference pulse in the same cycle
        cyc(1'b1, 1'b1);
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        // R7 again after reacquire, then random mix
        for (int i = 0; i < 30000; i++) begin
            bit mk = at_rev_end() ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 4999) == 0);
            bit mr = ($urandom_range(0, 7999) == 0);
            cyc(mk, mr);
        end
        // R8: random misplaced pulse from a clean lock
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 777; i++) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule